// File: doc/BRIEF.md
# Floating-point min/max and compare unit

This block is a purely combinational datapath for binary32 values. It takes two operands and a two-bit operation code, and returns one of four results: the smaller operand, the larger operand, a less-than flag or a less-or-equal flag. It also raises an invalid-operation flag.

Each operation comes in two flavours. Two instruction bits, passed straight from the instruction word, pick the flavour. Bit 13 switches min/max from the older rule to the newer rule. Under the older rule a NaN operand is skipped when the other operand is a number. Under the newer rule any NaN input forces the canonical NaN. Bit 14 switches the compares from signaling to quiet. A quiet compare raises invalid only for a signaling NaN.

The unit sits beside the floating-point register file and feeds its writeback mux. It holds no state.

Top module: `fp_minmax_cmp`

## Requirements
- R1: With op code 0 (min), `mm_res_o` is the numerically smaller operand. With op code 1 (max), it is the larger operand. This holds whenever neither operand is NaN.
- R2: For min and max, -0.0 (0x80000000) counts as smaller than +0.0 (0x00000000).
- R3: With `ins_b13_i`=0, min and max handle NaN as follows. If exactly one operand is NaN, the result is the other operand. If both are NaN, the result is the canonical NaN 0x7FC00000.
- R4: With `ins_b13_i`=1, min and max return 0x7FC00000 whenever either operand is NaN, quiet or signaling.
- R5: For min and max, `invalid_o` is 1 exactly when at least one operand is a signaling NaN. A signaling NaN has exponent all ones, mantissa bit 22 equal to 0, and a nonzero mantissa. A quiet NaN has exponent all ones and mantissa bit 22 equal to 1.
- R6: With op code 2 (less-than) and op code 3 (less-or-equal), `cmp_res_o` gives the numeric comparison of a against b. The two zeros compare equal. Any NaN operand gives 0.
- R7: With `ins_b14_i`=0, a compare sets `invalid_o` when either operand is any NaN.
- R8: With `ins_b14_i`=1, a compare sets `invalid_o` only when an operand is a signaling NaN. A quiet NaN alone leaves it 0.
- R9: `ins_b14_i` has no effect on min and max. `ins_b13_i` has no effect on the compares.
- R10: `mm_res_o` is 0 during a compare op. `cmp_res_o` is 0 during a min/max op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | 32 | First binary32 operand |
| op_b_i | input | 32 | Second binary32 operand |
| op_sel_i | input | 2 | 0 min, 1 max, 2 less-than, 3 less-or-equal |
| ins_b13_i | input | 1 | Instruction bit 13: NaN-propagating min/max |
| ins_b14_i | input | 1 | Instruction bit 14: quiet compare |
| mm_res_o | output | 32 | Min/max result |
| cmp_res_o | output | 1 | Compare result |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The hardest inputs to reach are the rare operand classes. Uniform random 32-bit words almost never give equal zeros of opposite sign, a signaling NaN paired with a quiet NaN, or two identical values. As a result, the zero ordering, the both-NaN result and the quiet/signaling flag split would barely be touched.

The stimulus therefore draws each operand from weighted classes: both zeros, quiet NaNs with random payloads, signaling NaNs with a forced nonzero payload, infinities, subnormals, normals, and a copy of the other operand. Both instruction bits are randomized on every op, so the unused bit is always moving. Directed vectors pin down each corner first.

// File: rtl/fp_mmc_pkg.sv
package fp_mmc_pkg;
  typedef enum logic [1:0] {
    OP_MIN = 2'd0,
    OP_MAX = 2'd1,
    OP_LT  = 2'd2,
    OP_LE  = 2'd3
  } mmc_op_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic nan;
    logic snan;
  } fp_cls_t;
endpackage

// File: rtl/fp_mmc_classify.sv
module fp_mmc_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0]        val_i,
  output fp_mmc_pkg::fp_cls_t cls_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  assign exp_f = val_i[W-2 -: EXP_W];
  assign man_f = val_i[MAN_W-1:0];

  always_comb begin
    cls_o.sign = val_i[W-1];
    cls_o.zero = (exp_f == '0) && (man_f == '0);
    cls_o.nan  = (&exp_f) && (man_f != '0);
    cls_o.snan = cls_o.nan && !man_f[MAN_W-1];
  end
endmodule

// File: rtl/fp_mmc_order.sv
module fp_mmc_order #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         lt_signed0_o,
  output logic         lt_num_o,
  output logic         eq_num_o
);
  logic [W-1:0] key_a, key_b;
  logic         both_zero;

  // map sign-magnitude onto unsigned total order (valid for non-NaN)
  always_comb begin
    key_a     = a_i[W-1] ? ~a_i : (a_i | (W'(1) << (W-1)));
    key_b     = b_i[W-1] ? ~b_i : (b_i | (W'(1) << (W-1)));
    both_zero = (a_i[W-2:0] == '0) && (b_i[W-2:0] == '0);
    lt_signed0_o = key_a < key_b;
    lt_num_o     = (key_a < key_b) && !both_zero;
    eq_num_o     = (key_a == key_b) || both_zero;
  end
endmodule

// File: rtl/fp_mmc_minmax.sv
module fp_mmc_minmax #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  input  fp_mmc_pkg::fp_cls_t cls_a_i,
  input  fp_mmc_pkg::fp_cls_t cls_b_i,
  input  logic                lt_i,
  input  logic                is_max_i,
  input  logic                prop_i,
  output logic [W-1:0]        res_o,
  output logic                inv_o
);
  localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  always_comb begin
    inv_o = cls_a_i.snan || cls_b_i.snan;
    if ((cls_a_i.nan && cls_b_i.nan) || (prop_i && (cls_a_i.nan || cls_b_i.nan)))
      res_o = CANON;
    else if (cls_a_i.nan)
      res_o = b_i;
    else if (cls_b_i.nan)
      res_o = a_i;
    else
      res_o = (lt_i ^ is_max_i) ? a_i : b_i;
    if (prop_i && (cls_a_i.nan || cls_b_i.nan))
      assert_prop_canon_R4: assert (res_o == CANON)
        else $error("propagating min/max did not give canonical NaN");
    if (!prop_i && cls_a_i.nan && !cls_b_i.nan)
      assert_skip_nan_R3: assert (res_o == b_i)
        else $error("legacy min/max did not skip NaN");
  end
endmodule

// File: rtl/fp_mmc_cmp.sv
module fp_mmc_cmp (
  input  fp_mmc_pkg::fp_cls_t cls_a_i,
  input  fp_mmc_pkg::fp_cls_t cls_b_i,
  input  logic                lt_i,
  input  logic                eq_i,
  input  logic                is_le_i,
  input  logic                quiet_i,
  output logic                res_o,
  output logic                inv_o
);
  logic any_nan, any_snan;

  always_comb begin
    any_nan  = cls_a_i.nan || cls_b_i.nan;
    any_snan = cls_a_i.snan || cls_b_i.snan;
    res_o    = !any_nan && (lt_i || (is_le_i && eq_i));
    inv_o    = quiet_i ? any_snan : any_nan;
    if (any_nan)
      assert_nan_false_R6: assert (!res_o)
        else $error("compare with NaN returned true");
    if (quiet_i && !any_snan)
      assert_quiet_inv_R8: assert (!inv_o)
        else $error("quiet compare raised invalid on quiet NaN");
  end
endmodule

// File: rtl/fp_minmax_cmp.sv
module fp_minmax_cmp #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic [1:0]   op_sel_i,
  input  logic         ins_b13_i,
  input  logic         ins_b14_i,
  output logic [W-1:0] mm_res_o,
  output logic         cmp_res_o,
  output logic         invalid_o
);
  import fp_mmc_pkg::*;

  logic [W-1:0] opnd [2];
  fp_cls_t      cls  [2];
  logic         lt_s0, lt_num, eq_num;
  logic [W-1:0] mm_val;
  logic         mm_inv, cmp_val, cmp_inv, is_cmp;

  assign opnd[0] = op_a_i;
  assign opnd[1] = op_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fp_mmc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val_i(opnd[g]), .cls_o(cls[g]));
  end

  fp_mmc_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .a_i(op_a_i), .b_i(op_b_i),
    .lt_signed0_o(lt_s0), .lt_num_o(lt_num), .eq_num_o(eq_num));

  fp_mmc_minmax #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_minmax (
    .a_i(op_a_i), .b_i(op_b_i), .cls_a_i(cls[0]), .cls_b_i(cls[1]),
    .lt_i(lt_s0), .is_max_i(op_sel_i == OP_MAX), .prop_i(ins_b13_i),
    .res_o(mm_val), .inv_o(mm_inv));

  fp_mmc_cmp u_cmp (
    .cls_a_i(cls[0]), .cls_b_i(cls[1]), .lt_i(lt_num), .eq_i(eq_num),
    .is_le_i(op_sel_i == OP_LE), .quiet_i(ins_b14_i),
    .res_o(cmp_val), .inv_o(cmp_inv));

  always_comb begin
    is_cmp    = op_sel_i[1];
    mm_res_o  = is_cmp ? '0 : mm_val;
    cmp_res_o = is_cmp & cmp_val;
    invalid_o = is_cmp ? cmp_inv : mm_inv;
    if (is_cmp)
      assert_mm_idle_R10: assert (mm_res_o == '0)
        else $error("min/max result not idle during compare");
    if (!is_cmp)
      assert_mm_inv_R5: assert (invalid_o == (cls[0].snan || cls[1].snan))
        else $error("min/max invalid flag mismatch");
  end
endmodule

// File: tb/fp_minmax_cmp_bench.sv
module fp_minmax_cmp_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b;
  logic [1:0]  op;
  logic        b13, b14;
  logic [31:0] mm_res;
  logic        cmp_res, inv;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;

  localparam logic [31:0] CNAN = 32'h7FC00000;

  always #4 clk = ~clk;

  fp_minmax_cmp u_fp_minmax_cmp (
    .op_a_i(a), .op_b_i(b), .op_sel_i(op), .ins_b13_i(b13), .ins_b14_i(b14),
    .mm_res_o(mm_res), .cmp_res_o(cmp_res), .invalid_o(inv));

  function automatic bit is_nan(logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction
  function automatic bit is_snan(logic [31:0] x);
    return is_nan(x) && !x[22];
  endfunction
  function automatic bit is_zero(logic [31:0] x);
    return x[30:0] == 0;
  endfunction

  // strict numeric less-than on non-NaN; zsign chooses -0 < +0
  function automatic bit less(logic [31:0] x, logic [31:0] y, bit zsign);
    if (is_zero(x) && is_zero(y)) return zsign && x[31] && !y[31];
    if (x[31] != y[31]) return x[31];
    if (!x[31]) return x[30:0] < y[30:0];
    return x[30:0] > y[30:0];
  endfunction

  function automatic logic [31:0] ref_mm(logic [31:0] x, logic [31:0] y,
                                         logic [1:0] o, bit p);
    if (o[1]) return 32'h0;
    if (is_nan(x) && is_nan(y)) return CNAN;
    if (p && (is_nan(x) || is_nan(y))) return CNAN;
    if (is_nan(x)) return y;
    if (is_nan(y)) return x;
    if (o == 2'd0) return less(x, y, 1) ? x : y;
    return less(y, x, 1) ? x : y;
  endfunction

  function automatic bit ref_cmp(logic [31:0] x, logic [31:0] y, logic [1:0] o);
    if (!o[1] || is_nan(x) || is_nan(y)) return 1'b0;
    if (o == 2'd2) return less(x, y, 0);
    return less(x, y, 0) || !less(y, x, 0);
  endfunction

  function automatic bit ref_inv(logic [31:0] x, logic [31:0] y,
                                 logic [1:0] o, bit q);
    if (!o[1] || q) return is_snan(x) || is_snan(y);
    return is_nan(x) || is_nan(y);
  endfunction

  function automatic string mm_tag(logic [31:0] x, logic [31:0] y, logic [1:0] o, bit p);
    if (o[1]) return "R10";
    if (is_nan(x) || is_nan(y)) return p ? "R4" : "R3";
    if (is_zero(x) && is_zero(y)) return "R2";
    return "R1/R9";
  endfunction

  task automatic apply(logic [31:0] x, logic [31:0] y, logic [1:0] o,
                       bit p13, bit p14);
    logic [31:0] em;
    bit ec, ei;
    @(posedge clk);
    a = x; b = y; op = o; b13 = p13; b14 = p14;
    em = ref_mm(x, y, o, p13);
    ec = ref_cmp(x, y, o);
    ei = ref_inv(x, y, o, p14);
    @(negedge clk);
    checks++;
    if (mm_res !== em) begin
      errors++;
      $display("FAIL %s mm_res a=%h b=%h op=%0d b13=%0d: actual %h expected %h",
               mm_tag(x, y, o, p13), x, y, o, p13, mm_res, em);
    end
    checks++;
    if (cmp_res !== ec) begin
      errors++;
      $display("FAIL %s cmp_res a=%h b=%h op=%0d: actual %0d expected %0d",
               o[1] ? "R6/R9" : "R10", x, y, o, cmp_res, ec);
    end
    checks++;
    if (inv !== ei) begin
      errors++;
      $display("FAIL %s invalid a=%h b=%h op=%0d b14=%0d: actual %0d expected %0d",
               !o[1] ? "R5" : (p14 ? "R8" : "R7"), x, y, o, p14, inv, ei);
    end
  endtask

  function automatic logic [31:0] pick(logic [31:0] other);
    logic [31:0] r = $urandom;
    case ($urandom % 9)
      0: return {r[31], 31'h0};
      1: return {r[31], 8'hFF, 1'b1, r[21:0]};
      2: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
      3: return {r[31], 8'hFF, 23'h0};
      4: return {r[31], 8'h00, r[22:0]};
      5: return other;
      6: return {~other[31], other[30:0]};
      default: return r;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a = 0; b = 0; op = 0; b13 = 0; b14 = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle state after reset: zeros in, min op
    apply(32'h0, 32'h0, 2'd0, 0, 0);
    // R1 ordinary min/max
    apply(32'h3F800000, 32'h40000000, 2'd0, 0, 0);
    apply(32'h3F800000, 32'h40000000, 2'd1, 1, 1);
    apply(32'hC0000000, 32'h3F800000, 2'd0, 0, 1);
    // R2 signed zeros
    apply(32'h00000000, 32'h80000000, 2'd0, 0, 0);
    apply(32'h80000000, 32'h00000000, 2'd1, 1, 0);
    // R3 legacy NaN skip, both NaN
    apply(32'h7FC00001, 32'h40400000, 2'd0, 0, 0);
    apply(32'h40400000, 32'h7F800001, 2'd1, 0, 1);
    apply(32'h7F800001, 32'hFFC00000, 2'd0, 0, 0);
    // R4 propagating NaN
    apply(32'h7FC00001, 32'h40400000, 2'd0, 1, 0);
    apply(32'h40400000, 32'h7F800001, 2'd1, 1, 0);
    // R6 compares, zeros equal
    apply(32'h80000000, 32'h00000000, 2'd2, 0, 0);
    apply(32'h80000000, 32'h00000000, 2'd3, 0, 0);
    apply(32'hBF800000, 32'h3F800000, 2'd2, 1, 1);
    // R7 / R8 quiet vs signaling
    apply(32'h7FC00000, 32'h3F800000, 2'd2, 0, 0);
    apply(32'h7FC00000, 32'h3F800000, 2'd2, 0, 1);
    apply(32'h3F800000, 32'h7F800001, 2'd3, 0, 1);
    // R10 idle outputs
    apply(32'h40000000, 32'h3F800000, 2'd3, 1, 0);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] x = pick($urandom);
      logic [31:0] y = pick(x);
      apply(x, y, 2'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule